// File: doc/BRIEF.md
# Virtual-Instruction Exception Classifier

This block sits in the trap path of a core that can run guest software under a hypervisor. Each cycle it may be handed one decoded instruction that has already been through the ordinary privilege checks. From the virtualization state it decides whether that instruction raises nothing, an illegal-instruction exception (cause 2) or a virtual-instruction exception (cause 22). Its inputs are the virtualization bit, the guest sub-mode (guest kernel or guest user), the current XLEN and the guest-user XLEN, an instruction class, a CSR address with its write intent, both counter-enable registers, and the trap-control bits of the machine and hypervisor status registers.

Inside the block, a small combinational CSR attribute table supplies each address's privilege level, read-only flag, high-half flag and low-half partner. The host-mode legality check that chooses between cause 22 and cause 2 always treats the machine trap-SRET and trap-VM bits as zero. A high-half CSR is judged through its low-half partner when XLEN is 32 and is always illegal when XLEN is wider. The result is registered and appears one cycle after the input strobe.

Top module: `virt_exc_classifier`

## Requirements
- R1: While reset is held and in the first cycle after it, `excValid` is 0, `excCause` is 0 and `excTval` is 0.
- R2: The outputs reflect the instruction strobed with `inValid` at the previous rising edge. After a cycle with `inValid` low, `excValid` is 0. An exception drives `excCause` to 2 (illegal) or 22 (virtual) and `excTval` to the instruction bits, and the same rule holds for both causes. With no exception, cause and trap value are 0.
- R3: With `virtOn`=0 (host supervisor mode), cause 22 never appears, and the real trap bits apply. The following are illegal: SRET (class 4) when `mTrapSret`=1, SFENCE (class 5) when `mTrapVm`=1, CSR 0x180 (class 1) when `mTrapVm`=1, WFI (class 3) when `mTrapWait`=1, a machine-level CSR (address bits [9:8]=3), a write to a read-only CSR (bits [11:10]=3), and an unimplemented CSR.
- R4: With `virtOn`=1, a CSR access (class 1) that host mode would refuse, judged with trap-VM taken as 0, is illegal. Otherwise it raises 22 in two cases. In guest-kernel mode the target is hypervisor-level (bits [9:8]=2). In guest-user mode the target is supervisor- or hypervisor-level.
- R5: With `virtOn`=1, `mTrapSret` and `mTrapVm` have no effect. SRET in guest-kernel mode with `hTrapSret`=0 and CSR 0x180 with `hTrapVm`=0 raise nothing.
- R6: A high-half CSR (0xC80-0xC9F, 0x15D, 0x25D, 0x615, 0x890) is illegal whenever the XLEN that applies to it is not 32. That XLEN is `vuXlen32` for a user-level CSR (bits [9:8]=0, not read-only) accessed in guest-kernel mode, and `xlen32` otherwise.
- R7: When the applicable XLEN is 32, a high-half CSR access gives the same outcome as the same access to its low-half partner. A counter's partner is its address minus 0x080. The others pair as 0x15D-0x14D, 0x25D-0x24D, 0x615-0x605 and 0x890-0x810.
- R8: Counter CSRs are 0xC00-0xC1F, and address bits [4:0] pick the enable bit. A counter whose `mCounterEn` bit is 0 is illegal in every mode. With `virtOn`=1, a counter whose `mCounterEn` bit is 1 and `hCounterEn` bit is 0 raises 22.
- R9: Hypervisor load, store and fence instructions (class 2) raise 22 when `virtOn`=1 and nothing when `virtOn`=0.
- R10: WFI (class 3) is illegal in any mode when `mTrapWait`=1. When `mTrapWait`=0 it raises 22 in guest-user mode, and in guest-kernel mode when `hTrapWait`=1.
- R11: In guest-user mode, SRET (class 4) and SFENCE (class 5) raise 22. In guest-kernel mode, SRET raises 22 when `hTrapSret`=1, and SFENCE or CSR 0x180 raises 22 when `hTrapVm`=1.
- R12: Class 6 (not valid in host mode for any operands) is always illegal. Class 0 (ordinary instruction) never raises an exception.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Instruction strobe |
| virtOn | input | 1 | Virtualization bit |
| guestUser | input | 1 | 1 = guest user mode, 0 = guest kernel mode (used when virtOn=1) |
| xlen32 | input | 1 | Current XLEN is 32 |
| vuXlen32 | input | 1 | Guest-user XLEN is 32 |
| instrClass | input | 3 | Instruction class code |
| instrBits | input | INSTR_W | Raw instruction bits |
| csrAddr | input | 12 | CSR address (class 1) |
| csrWrite | input | 1 | CSR access writes |
| mCounterEn | input | CNT_W | Machine counter-enable register |
| hCounterEn | input | CNT_W | Hypervisor counter-enable register |
| mTrapWait | input | 1 | Machine timeout-wait bit |
| mTrapSret | input | 1 | Machine trap-SRET bit |
| mTrapVm | input | 1 | Machine trap-virtual-memory bit |
| hTrapWait | input | 1 | Hypervisor guest timeout-wait bit |
| hTrapSret | input | 1 | Hypervisor guest trap-SRET bit |
| hTrapVm | input | 1 | Hypervisor guest trap-virtual-memory bit |
| excValid | output | 1 | Exception raised (registered) |
| excCause | output | CAUSE_W | Cause code, 2 or 22, else 0 |
| excTval | output | INSTR_W | Trap value, the instruction bits on an exception |

## Verification
Every result is due exactly one rising edge after its strobe, because the classification is combinational and only the output stage is registered. The bench therefore sets the inputs on a falling edge, waits for the next falling edge and compares all three outputs there, while the following stimulus is already being applied. The idle test drops the strobe for one cycle and checks at the following falling edge that the valid flag has cleared. The exhaustive sweep over mode, XLEN, enable bits, write intent and trap-VM uses the same one-cycle spacing against a reference model in the bench.

// File: rtl/vexc_pkg.sv
package vexc_pkg;
  localparam int CSR_AW = 12;
  localparam int CAUSE_ILLEGAL = 2;
  localparam int CAUSE_VIRTUAL = 22;

  typedef enum logic [2:0] {
    IC_PLAIN  = 3'd0,
    IC_CSR    = 3'd1,
    IC_HYPMEM = 3'd2,
    IC_WFI    = 3'd3,
    IC_SRET   = 3'd4,
    IC_SFENCE = 3'd5,
    IC_BAD    = 3'd6
  } instrClass_e;

  typedef struct packed {
    logic              impl;
    logic [1:0]        priv;
    logic              readOnly;
    logic              highHalf;
    logic              userLevel;
    logic              isCounter;
    logic              isSatp;
    logic [CSR_AW-1:0] partner;
  } csrAttr_t;

  typedef struct packed {
    logic load;
    logic raiseIll;
    logic raiseVirt;
  } ctrlStrobe_t;
endpackage

// File: rtl/vexc_csr_table.sv
module vexc_csr_table
  import vexc_pkg::*;
(
  input  logic [CSR_AW-1:0] addr,
  output csrAttr_t          attr
);
  always_comb begin
    attr           = '0;
    attr.priv      = addr[9:8];
    attr.readOnly  = (addr[11:10] == 2'b11);
    attr.userLevel = (addr[9:8] == 2'b00) && (addr[11:10] != 2'b11);
    attr.partner   = addr;
    if (addr[11:5] == 7'h60) begin
      attr.impl      = 1'b1;
      attr.isCounter = 1'b1;
    end else if (addr[11:5] == 7'h64) begin
      attr.impl     = 1'b1;
      attr.highHalf = 1'b1;
      attr.partner  = addr - 12'h080;
    end else begin
      case (addr)
        12'h100, 12'h105, 12'h140, 12'h14D,
        12'h200, 12'h24D, 12'h600, 12'h605,
        12'h300, 12'h810: attr.impl = 1'b1;
        12'h180: begin
          attr.impl   = 1'b1;
          attr.isSatp = 1'b1;
        end
        12'h15D: begin
          attr.impl = 1'b1; attr.highHalf = 1'b1; attr.partner = 12'h14D;
        end
        12'h25D: begin
          attr.impl = 1'b1; attr.highHalf = 1'b1; attr.partner = 12'h24D;
        end
        12'h615: begin
          attr.impl = 1'b1; attr.highHalf = 1'b1; attr.partner = 12'h605;
        end
        12'h890: begin
          attr.impl = 1'b1; attr.highHalf = 1'b1; attr.partner = 12'h810;
        end
        default: attr.impl = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/vexc_ctrl.sv
module vexc_ctrl
  import vexc_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             inValid,
  input  logic             virtOn,
  input  logic             guestUser,
  input  logic             xlen32,
  input  logic             vuXlen32,
  input  logic [2:0]       instrClass,
  input  logic             csrWrite,
  input  csrAttr_t         attrSelf,
  input  csrAttr_t         attrLow,
  input  logic [CNT_W-1:0] mCounterEn,
  input  logic [CNT_W-1:0] hCounterEn,
  input  logic             mTrapWait,
  input  logic             mTrapSret,
  input  logic             mTrapVm,
  input  logic             hTrapWait,
  input  logic             hTrapSret,
  input  logic             hTrapVm,
  output ctrlStrobe_t      strobe
);
  localparam int IDX_W = (CNT_W > 1) ? $clog2(CNT_W) : 1;

  csrAttr_t   tgt;
  logic [IDX_W-1:0] idx;
  logic widthOk, hsBase, hsReal, guestBlock, csrIll, csrVirt;
  logic ill, virt;

  always_comb begin
    tgt     = attrSelf.highHalf ? attrLow : attrSelf;
    idx     = attrSelf.partner[IDX_W-1:0];
    widthOk = (virtOn && !guestUser && attrSelf.userLevel) ? vuXlen32 : xlen32;
    hsBase  = tgt.impl && (tgt.priv != 2'b11) && !(csrWrite && tgt.readOnly)
              && !(tgt.isCounter && !mCounterEn[idx]);
    hsReal  = hsBase && !(tgt.isSatp && mTrapVm);
    if (guestUser)
      guestBlock = (tgt.priv == 2'b01) || (tgt.priv == 2'b10)
                   || (tgt.isCounter && !hCounterEn[idx]);
    else
      guestBlock = (tgt.priv == 2'b10) || (tgt.isCounter && !hCounterEn[idx])
                   || (tgt.isSatp && hTrapVm);

    csrIll  = 1'b0;
    csrVirt = 1'b0;
    if (!attrSelf.impl || (attrSelf.highHalf && !widthOk)) csrIll = 1'b1;
    else if (!virtOn)  csrIll = !hsReal;
    else if (!hsBase)  csrIll = 1'b1;
    else               csrVirt = guestBlock;

    ill  = 1'b0;
    virt = 1'b0;
    case (instrClass)
      IC_CSR:    begin ill = csrIll; virt = csrVirt; end
      IC_HYPMEM: virt = virtOn;
      IC_WFI: begin
        if (mTrapWait) ill = 1'b1;
        else if (virtOn) virt = guestUser || hTrapWait;
      end
      IC_SRET: begin
        if (!virtOn) ill = mTrapSret;
        else virt = guestUser || hTrapSret;
      end
      IC_SFENCE: begin
        if (!virtOn) ill = mTrapVm;
        else virt = guestUser || hTrapVm;
      end
      IC_BAD:  ill = 1'b1;
      default: ill = 1'b0;
    endcase

    strobe.load      = inValid;
    strobe.raiseIll  = inValid && ill;
    strobe.raiseVirt = inValid && virt;
  end
endmodule

// File: rtl/vexc_datapath.sv
module vexc_datapath
  import vexc_pkg::*;
#(
  parameter int INSTR_W = 32,
  parameter int CAUSE_W = 5
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctrlStrobe_t        strobe,
  input  logic [INSTR_W-1:0] instrBits,
  output logic               excValid,
  output logic [CAUSE_W-1:0] excCause,
  output logic [INSTR_W-1:0] excTval
);
  localparam logic [CAUSE_W-1:0] CODE_ILL  = CAUSE_W'(CAUSE_ILLEGAL);
  localparam logic [CAUSE_W-1:0] CODE_VIRT = CAUSE_W'(CAUSE_VIRTUAL);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      excValid <= 1'b0;
      excCause <= '0;
      excTval  <= '0;
    end else if (strobe.load && (strobe.raiseIll || strobe.raiseVirt)) begin
      excValid <= 1'b1;
      excCause <= strobe.raiseVirt ? CODE_VIRT : CODE_ILL;
      excTval  <= instrBits;
    end else begin
      excValid <= 1'b0;
      excCause <= '0;
      excTval  <= '0;
    end
  end
endmodule

// File: rtl/virt_exc_classifier.sv
module virt_exc_classifier
  import vexc_pkg::*;
#(
  parameter int INSTR_W = 32,
  parameter int CNT_W   = 32,
  parameter int CAUSE_W = 5
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               inValid,
  input  logic               virtOn,
  input  logic               guestUser,
  input  logic               xlen32,
  input  logic               vuXlen32,
  input  logic [2:0]         instrClass,
  input  logic [INSTR_W-1:0] instrBits,
  input  logic [11:0]        csrAddr,
  input  logic               csrWrite,
  input  logic [CNT_W-1:0]   mCounterEn,
  input  logic [CNT_W-1:0]   hCounterEn,
  input  logic               mTrapWait,
  input  logic               mTrapSret,
  input  logic               mTrapVm,
  input  logic               hTrapWait,
  input  logic               hTrapSret,
  input  logic               hTrapVm,
  output logic               excValid,
  output logic [CAUSE_W-1:0] excCause,
  output logic [INSTR_W-1:0] excTval
);
  csrAttr_t    attrSelf, attrLow;
  ctrlStrobe_t strobe;

  vexc_csr_table selfLookup_i (.addr(csrAddr),          .attr(attrSelf));
  vexc_csr_table lowLookup_i  (.addr(attrSelf.partner), .attr(attrLow));

  vexc_ctrl #(.CNT_W(CNT_W)) ctrl_i (
    .inValid(inValid), .virtOn(virtOn), .guestUser(guestUser),
    .xlen32(xlen32), .vuXlen32(vuXlen32), .instrClass(instrClass),
    .csrWrite(csrWrite), .attrSelf(attrSelf), .attrLow(attrLow),
    .mCounterEn(mCounterEn), .hCounterEn(hCounterEn),
    .mTrapWait(mTrapWait), .mTrapSret(mTrapSret), .mTrapVm(mTrapVm),
    .hTrapWait(hTrapWait), .hTrapSret(hTrapSret), .hTrapVm(hTrapVm),
    .strobe(strobe)
  );

  vexc_datapath #(.INSTR_W(INSTR_W), .CAUSE_W(CAUSE_W)) dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .instrBits(instrBits),
    .excValid(excValid), .excCause(excCause), .excTval(excTval)
  );
endmodule

// File: rtl/vexc_checker.sv
module vexc_checker
  import vexc_pkg::*;
#(
  parameter int INSTR_W = 32,
  parameter int CAUSE_W = 5
) (
  input logic               clk,
  input logic               rstN,
  input logic               inValid,
  input logic               virtOn,
  input logic [2:0]         instrClass,
  input logic [INSTR_W-1:0] instrBits,
  input logic               excValid,
  input logic [CAUSE_W-1:0] excCause,
  input logic [INSTR_W-1:0] excTval
);
  // R2
  valid_needs_strobe_chk: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> !excValid);
  // R2
  tval_carries_instr_chk: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> (excTval == (excValid ? $past(instrBits) : '0)));
  // R2
  cause_code_legal_chk: assert property (@(posedge clk) disable iff (!rstN)
    excValid |-> (excCause == CAUSE_W'(CAUSE_ILLEGAL) || excCause == CAUSE_W'(CAUSE_VIRTUAL)));
  // R3
  host_no_virtual_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && !virtOn) |=> (excCause != CAUSE_W'(CAUSE_VIRTUAL)));
  // R9
  hyp_guest_virtual_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && virtOn && instrClass == IC_HYPMEM) |=> (excValid && excCause == CAUSE_W'(CAUSE_VIRTUAL)));
  // R12
  bad_class_illegal_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && instrClass == IC_BAD) |=> (excValid && excCause == CAUSE_W'(CAUSE_ILLEGAL)));
endmodule

bind virt_exc_classifier vexc_checker #(.INSTR_W(INSTR_W), .CAUSE_W(CAUSE_W)) chk_i (.*);

// File: tb/virt_exc_classifier_tb_top.sv
module virt_exc_classifier_tb_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic inValid = 0, virtOn = 0, guestUser = 0, xlen32 = 0, vuXlen32 = 0;
  logic [2:0]  instrClass = 0;
  logic [31:0] instrBits = 0;
  logic [11:0] csrAddr = 0;
  logic        csrWrite = 0;
  logic [31:0] mCounterEn = 0, hCounterEn = 0;
  logic mTrapWait = 0, mTrapSret = 0, mTrapVm = 0, hTrapWait = 0, hTrapSret = 0, hTrapVm = 0;
  logic        excValid;
  logic [4:0]  excCause;
  logic [31:0] excTval;
  int errors = 0, checks = 0;

  always #2 clk = ~clk;

  virt_exc_classifier dut_i (.*);

  typedef struct packed {
    logic v, g, x32, vx32;
    logic [2:0] cls;
    logic [11:0] addr;
    logic wr, mc, hc, tw, tsr, tvm, vtw, vtsr, vtvm;
    logic [4:0] exp;
  } vec_t;

  localparam int NV = 32;
  localparam vec_t VECS [NV] = '{
    '{1'b0,1'b0,1'b0,1'b0,3'd1,12'h300,1'b0,1'b1,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,5'd2},  // R3 machine CSR
    '{1'b0,1'b0,1'b0,1'b0,3'd4,12'h000,1'b0,1'b1,1'b1,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,5'd2},  // R3 SRET trap
    '{1'b0,1'b0,1'b0,1'b0,3'd5,12'h000,1'b0,1'b1,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,5'd0},  // R3 SFENCE ok
    '{1'b0,1'b0,1'b0,1'b0,3'd1,12'h180,1'b0,1'b1,1'b1,1'b0,1'b0,1'b1,1'b0,1'b0,1'b0,5'd2},  // R3 satp trap
    '{1'b0,1'b0,1'b0,1'b0,3'd1,12'h7FF,1'b0,1'b1,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,5'd2},  // R3 unimplemented
    '{1'b1,1'b0,1'b0,1'b0,3'd4,12'h000,1'b0,1'b1,1'b1,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,5'd0},  // R5 TSR ignored
    '{1'b1,1'b0,1'b0,1'b0,3'd1,12'h180,1'b0,1'b1,1'b1,1'b0,1'b0,1'b1,1'b0,1'b0,1'b0,5'd0},  // R5 TVM ignored
    '{1'b1,1'b0,1'b0,1'b0,3'd1,12'h180,1'b0,1'b1,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,5'd22}, // R11 satp VTVM
    '{1'b1,1'b1,1'b0,1'b0,3'd1,12'h100,1'b1,1'b1,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,5'd22}, // R4 VU sup CSR
    '{1'b1,1'b0,1'b0,1'b0,3'd1,12'h600,1'b0,1'b1,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,5'd22}, // R4 VS hyp CSR
    '{1'b1,1'b0,1'b0,1'b0,3'd1,12'h300,1'b0,1'b1,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,5'd2},  // R4 machine CSR
    '{1'b1,1'b0,1'b0,1'b0,3'd1,12'hC01,1'b1,1'b1,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,5'd2},  // R4 RO write
    '{1'b1,1'b0,1'b0,1'b0,3'd1,12'hC81,1'b0,1'b1,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,5'd2},  // R6 wide high
    '{1'b1,1'b0,1'b1,1'b0,3'd1,12'hC81,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,5'd22}, // R7 high counter
    '{1'b1,1'b0,1'b1,1'b0,3'd1,12'h890,1'b0,1'b1,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,5'd2},  // R6 user VU wide
    '{1'b1,1'b0,1'b0,1'b1,3'd1,12'h890,1'b0,1'b1,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,5'd0},  // R6 user VU 32
    '{1'b1,1'b1,1'b1,1'b0,3'd1,12'h615,1'b0,1'b1,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,5'd22}, // R7 hyp high
    '{1'b1,1'b0,1'b1,1'b0,3'd1,12'h15D,1'b0,1'b1,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,5'd0},  // R7 sup high VS
    '{1'b0,1'b0,1'b0,1'b0,3'd1,12'h15D,1'b0,1'b1,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,5'd2},  // R6 host wide
    '{1'b1,1'b0,1'b0,1'b0,3'd1,12'hC02,1'b0,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,5'd2},  // R8 mcounteren 0
    '{1'b1,1'b1,1'b0,1'b0,3'd1,12'hC02,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,5'd22}, // R8 hcounteren 0
    '{1'b1,1'b1,1'b0,1'b0,3'd2,12'h000,1'b0,1'b1,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,5'd22}, // R9 guest
    '{1'b0,1'b0,1'b0,1'b0,3'd2,12'h000,1'b0,1'b1,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,5'd0},  // R9 host
    '{1'b1,1'b1,1'b0,1'b0,3'd3,12'h000,1'b0,1'b1,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,5'd22}, // R10 VU TW0
    '{1'b1,1'b1,1'b0,1'b0,3'd3,12'h000,1'b0,1'b1,1'b1,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,5'd2},  // R10 VU TW1
    '{1'b1,1'b0,1'b0,1'b0,3'd3,12'h000,1'b0,1'b1,1'b1,1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,5'd22}, // R10 VS VTW
    '{1'b1,1'b0,1'b0,1'b0,3'd3,12'h000,1'b0,1'b1,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,5'd0},  // R10 VS ok
    '{1'b1,1'b1,1'b0,1'b0,3'd5,12'h000,1'b0,1'b1,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,5'd22}, // R11 VU SFENCE
    '{1'b1,1'b1,1'b0,1'b0,3'd4,12'h000,1'b0,1'b1,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,5'd22}, // R11 VU SRET
    '{1'b1,1'b0,1'b0,1'b0,3'd4,12'h000,1'b0,1'b1,1'b1,1'b0,1'b0,1'b0,1'b0,1'b1,1'b0,5'd22}, // R11 VS VTSR
    '{1'b0,1'b0,1'b0,1'b0,3'd6,12'h000,1'b0,1'b1,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,5'd2},  // R12 bad
    '{1'b1,1'b1,1'b0,1'b0,3'd0,12'h000,1'b0,1'b1,1'b1,1'b1,1'b1,1'b1,1'b1,1'b1,1'b1,5'd0}   // R12 plain
  };

  function automatic bit tbKnown(logic [11:0] a);
    if (a >= 12'hC00 && a <= 12'hC1F) return 1;
    if (a >= 12'hC80 && a <= 12'hC9F) return 1;
    return a inside {12'h100, 12'h105, 12'h140, 12'h14D, 12'h15D, 12'h180, 12'h200,
                     12'h24D, 12'h25D, 12'h300, 12'h600, 12'h605, 12'h615, 12'h810, 12'h890};
  endfunction

  function automatic bit tbHigh(logic [11:0] a);
    return (a >= 12'hC80 && a <= 12'hC9F) || (a inside {12'h15D, 12'h25D, 12'h615, 12'h890});
  endfunction

  function automatic logic [11:0] tbLow(logic [11:0] a);
    if (a >= 12'hC80 && a <= 12'hC9F) return a - 12'h080;
    case (a)
      12'h15D: return 12'h14D;
      12'h25D: return 12'h24D;
      12'h615: return 12'h605;
      12'h890: return 12'h810;
      default: return a;
    endcase
  endfunction

  function automatic bit tbHostAllows(logic [11:0] a, bit tvmBit);
    bit isCnt;
    isCnt = (a >= 12'hC00 && a <= 12'hC1F);
    if (!tbKnown(a) || a[9:8] == 2'd3) return 0;
    if (csrWrite && a[11:10] == 2'd3) return 0;
    if (isCnt && !mCounterEn[a[4:0]]) return 0;
    if (a == 12'h180 && tvmBit) return 0;
    return 1;
  endfunction

  function automatic int refCsr(logic [11:0] a);
    logic [11:0] e;
    bit userCsr, use32, isCnt;
    if (!tbKnown(a)) return 2;
    userCsr = (a[9:8] == 2'd0) && (a[11:10] != 2'd3);
    use32 = (virtOn && !guestUser && userCsr) ? vuXlen32 : xlen32;
    if (tbHigh(a) && !use32) return 2;
    e = tbLow(a);
    if (!virtOn) return tbHostAllows(e, mTrapVm) ? 0 : 2;
    if (!tbHostAllows(e, 1'b0)) return 2;
    isCnt = (e >= 12'hC00 && e <= 12'hC1F);
    if (isCnt && !hCounterEn[e[4:0]]) return 22;
    if (e[9:8] == 2'd2) return 22;
    if (guestUser && e[9:8] == 2'd1) return 22;
    if (!guestUser && e == 12'h180 && hTrapVm) return 22;
    return 0;
  endfunction

  task automatic checkOut(input string tag, input int exp);
    logic [31:0] expTval;
    @(negedge clk);
    checks++;
    expTval = (exp != 0) ? instrBits : 32'h0;
    if (excValid !== (exp != 0) || excCause !== 5'(exp) || excTval !== expTval) begin
      errors++;
      $display("FAIL %s: got valid=%0b cause=%0d tval=%h, expected valid=%0b cause=%0d tval=%h",
               tag, excValid, excCause, excTval, exp != 0, exp, expTval);
    end
    inValid = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got no finish, expected finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 outputs during reset
    checks++;
    if (excValid !== 0 || excCause !== 0 || excTval !== 0) begin
      errors++;
      $display("FAIL R1: got %0b/%0d/%h, expected 0/0/0", excValid, excCause, excTval);
    end
    rstN = 1'b1;
    @(negedge clk);
    // R1 first cycle after reset
    checks++;
    if (excValid !== 0 || excCause !== 0 || excTval !== 0) begin
      errors++;
      $display("FAIL R1: got %0b/%0d/%h after release, expected 0/0/0", excValid, excCause, excTval);
    end

    // directed vector table (R3..R12)
    for (int i = 0; i < NV; i++) begin
      virtOn = VECS[i].v; guestUser = VECS[i].g; xlen32 = VECS[i].x32; vuXlen32 = VECS[i].vx32;
      instrClass = VECS[i].cls; csrAddr = VECS[i].addr; csrWrite = VECS[i].wr;
      mCounterEn = {32{VECS[i].mc}}; hCounterEn = {32{VECS[i].hc}};
      mTrapWait = VECS[i].tw; mTrapSret = VECS[i].tsr; mTrapVm = VECS[i].tvm;
      hTrapWait = VECS[i].vtw; hTrapSret = VECS[i].vtsr; hTrapVm = VECS[i].vtvm;
      instrBits = 32'hA5000000 + 32'(i);
      inValid = 1'b1;
      checkOut($sformatf("vector %0d", i), int'(VECS[i].exp));
    end

    // R2 idle cycle clears valid
    virtOn = 1'b0; instrClass = 3'd6; inValid = 1'b0;
    checkOut("R2 idle", 0);

    // R8 selected counter bit only
    virtOn = 1'b1; guestUser = 1'b0; instrClass = 3'd1; csrAddr = 12'hC05; csrWrite = 1'b0;
    mCounterEn = 32'h0000_0020; hCounterEn = 32'hFFFF_FFDF; instrBits = 32'h1234_5678;
    inValid = 1'b1;
    checkOut("R8 bit5 hcounteren clear", 22);

    // exhaustive sweep against the reference model (R4 R6 R7 R8 R3)
    begin
      logic [11:0] addrs [12] = '{12'hC03, 12'hC83, 12'h100, 12'h180, 12'h15D, 12'h600,
                                  12'h615, 12'h25D, 12'h890, 12'h810, 12'h300, 12'hC05};
      for (int ai = 0; ai < 12; ai++) begin
        for (int combo = 0; combo < 256; combo++) begin
          string tag;
          virtOn = combo[0]; guestUser = combo[1]; xlen32 = combo[2]; vuXlen32 = combo[3];
          mCounterEn = combo[4] ? '1 : '0; hCounterEn = combo[5] ? '1 : '0;
          csrWrite = combo[6]; mTrapVm = combo[7];
          mTrapWait = 0; mTrapSret = 0; hTrapWait = 0; hTrapSret = 0; hTrapVm = combo[1];
          instrClass = 3'd1; csrAddr = addrs[ai];
          instrBits = {addrs[ai], 12'h0, 8'(combo)};
          if (tbHigh(addrs[ai])) tag = "R7 sweep";
          else if (addrs[ai][11:8] == 4'hC) tag = "R8 sweep";
          else if (combo[0]) tag = "R4 sweep";
          else tag = "R3 sweep";
          inValid = 1'b1;
          checkOut(tag, refCsr(addrs[ai]));
        end
      end
    end

    // R1 mid-run reset clears a pending exception
    virtOn = 1'b0; instrClass = 3'd6; instrBits = 32'hDEAD_BEEF; inValid = 1'b1;
    @(negedge clk);
    inValid = 1'b0; rstN = 1'b0;
    checkOut("R1 before reset", 0);
    rstN = 1'b1;

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule